// File: doc/BRIEF.md
# Critical Conduction Switching Sequencer

This block produces the gate-drive pulse train for a boost converter that runs in critical conduction mode with constant on-time. Analog front ends reduce the inductor current, the output current and the loop voltage to digital comparator flags and an on-time count word. The sequencer turns those flags into one drive signal. A pulse ends when its programmed count runs out, or earlier when a current-limit comparator trips after its leading-edge blanking window. The dimming state picks which of two limit comparators applies. The next pulse starts a fixed delay after a blanked zero-current detection. If no such detection arrives, a long watchdog starts it instead.

A separate hard-stop comparator at a higher current level has its own, shorter blanking window. Each trip of this comparator ends the pulse and emits a one-cycle event strobe, so that fault logic elsewhere can count consecutive events. All durations are parameters counted in clock cycles. The defaults assume a 100 MHz reference clock. The control and status pins are plain levels and strobes. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `crm_switch_seq`

## Requirements
- R1: The on-time count is captured at the rising edge of `drive`. With no comparator trip, `drive` stays high for exactly that many clock cycles, including a count of 1. Changing `on_count` while `drive` is high does not change the pulse in progress.
- R2: A current-limit trip seen in on-cycle t (counted from 0 at the rising edge) with t >= LEB_LIM ends the pulse, so the width is t+1. Trips during on-cycles 0 to LEB_LIM-1 are ignored.
- R3: With `dim_active` high, only `ilim_red` acts as the current limit and `ilim_nom` has no effect. With `dim_active` low, only `ilim_nom` acts and `ilim_red` has no effect.
- R4: A `ilim_stop` trip in on-cycle t >= LEB_STOP ends the pulse, so the width is t+1. It also raises `stop_evt` for exactly one cycle, starting at the edge where `drive` falls. Trips in on-cycles below LEB_STOP are ignored and produce no strobe.
- R5: The off-time is counted from 0 at the falling edge of `drive`. `zcd_flag` is ignored during off-cycles 0 to ZCD_BLANK-1.
- R6: A `zcd_flag` seen in off-cycle u >= ZCD_BLANK raises `drive` after ZCD_DELAY more cycles. The low time is then u+ZCD_DELAY+1 cycles, and no timeout strobe is emitted.
- R7: If no valid detection has been seen by off-cycle ZCD_TIMEOUT-1, `drive` rises after exactly ZCD_TIMEOUT low cycles. `zcd_tmo_evt` is then high for one cycle, at the same edge. A detection in that last off-cycle wins over the timeout.
- R8: Low `enable` forces `drive` low at the next clock edge and holds the sequencer idle, whatever the other inputs do. When `enable` goes high, the first pulse starts at the next edge.
- R9: A start with `on_count` equal to 0 produces no pulse. The sequencer then ignores `zcd_flag` and waits ZCD_TIMEOUT cycles. After that it emits `zcd_tmo_evt` and tries to start again.
- R10: During reset, `drive`, `stop_evt` and `zcd_tmo_evt` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run permission; low forces idle |
| dim_active | input | 1 | Selects the reduced current-limit flag |
| ilim_nom | input | 1 | Inductor current above the normal limit |
| ilim_red | input | 1 | Inductor current above the reduced limit |
| ilim_stop | input | 1 | Inductor current above the hard-stop level |
| zcd_flag | input | 1 | Output current near zero |
| on_count | input | ON_W | Programmed on-time in clock cycles |
| drive | output | 1 | Gate-drive pulse |
| stop_evt | output | 1 | One-cycle strobe per hard-stop termination |
| zcd_tmo_evt | output | 1 | One-cycle strobe when the watchdog starts a pulse |

## Verification
Each pulse is ended in one of several ways: by count expiry, by the selected limit, by the unselected limit (which must not act) and by the hard-stop comparator. Measuring the width separates these sources and pins down the one-cycle turn-off latency. Comparator glitches confined to the blanking windows must leave the width at the full count. Zero-current detections are placed before the blank, inside it, after it and in the final watchdog cycle. These separate blank handling, delay counting and the priority between detection and timeout. Random pulse lengths and trip positions, together with enable drops and a zero count, cover orderings that the directed cases miss.

// File: rtl/crm_seq_pkg.sv
package crm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON,
    ST_OFF,
    ST_DELAY,
    ST_SKIP
  } seq_state_e;

  function automatic int seq_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/crm_on_term.sv
module crm_on_term #(
  parameter int ON_W     = 12,
  parameter int TMR_W    = 14,
  parameter int LEB_LIM  = 32,
  parameter int LEB_STOP = 12
) (
  input  logic [TMR_W-1:0] tmr,
  input  logic [ON_W-1:0]  len,
  input  logic             dim_active,
  input  logic             ilim_nom,
  input  logic             ilim_red,
  input  logic             ilim_stop,
  output logic             end_on,
  output logic             stop_hit
);

  logic lim_sel, lim_open, stop_open, count_done;

  always_comb begin
    lim_sel    = dim_active ? ilim_red : ilim_nom;
    lim_open   = tmr >= TMR_W'(LEB_LIM);
    stop_open  = tmr >= TMR_W'(LEB_STOP);
    count_done = (tmr + TMR_W'(1)) >= TMR_W'(len);
    stop_hit   = stop_open && ilim_stop;
    end_on     = count_done || stop_hit || (lim_open && lim_sel);
  end

endmodule

// File: rtl/crm_off_arm.sv
module crm_off_arm #(
  parameter int TMR_W       = 14,
  parameter int ZCD_BLANK   = 30,
  parameter int ZCD_TIMEOUT = 3200
) (
  input  logic [TMR_W-1:0] tmr,
  input  logic             zcd_en,
  input  logic             zcd_flag,
  output logic             zcd_valid,
  output logic             tmo_hit
);

  always_comb begin
    zcd_valid = zcd_en && zcd_flag && (tmr >= TMR_W'(ZCD_BLANK));
    tmo_hit   = tmr == TMR_W'(ZCD_TIMEOUT - 1);
  end

endmodule

// File: rtl/crm_switch_seq.sv
module crm_switch_seq
  import crm_seq_pkg::*;
#(
  parameter int ON_W        = 12,
  parameter int LEB_LIM     = 32,
  parameter int LEB_STOP    = 12,
  parameter int ZCD_BLANK   = 30,
  parameter int ZCD_DELAY   = 50,
  parameter int ZCD_TIMEOUT = 3200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            dim_active,
  input  logic            ilim_nom,
  input  logic            ilim_red,
  input  logic            ilim_stop,
  input  logic            zcd_flag,
  input  logic [ON_W-1:0] on_count,
  output logic            drive,
  output logic            stop_evt,
  output logic            zcd_tmo_evt
);

  localparam int SPAN  = seq_max3(ZCD_TIMEOUT, 1 << ON_W, ZCD_DELAY);
  localparam int TMR_W = $clog2(SPAN + 1) + 1;

  seq_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [ON_W-1:0]  len_q, len_d;
  logic             stop_q, stop_d, tmo_q, tmo_d;
  logic             end_on, stop_hit, zcd_valid, tmo_hit, delay_done, launch;

  crm_on_term #(
    .ON_W(ON_W), .TMR_W(TMR_W), .LEB_LIM(LEB_LIM), .LEB_STOP(LEB_STOP)
  ) u_term (
    .tmr(tmr_q), .len(len_q), .dim_active(dim_active),
    .ilim_nom(ilim_nom), .ilim_red(ilim_red), .ilim_stop(ilim_stop),
    .end_on(end_on), .stop_hit(stop_hit)
  );

  crm_off_arm #(
    .TMR_W(TMR_W), .ZCD_BLANK(ZCD_BLANK), .ZCD_TIMEOUT(ZCD_TIMEOUT)
  ) u_arm (
    .tmr(tmr_q), .zcd_en(st_q == ST_OFF), .zcd_flag(zcd_flag),
    .zcd_valid(zcd_valid), .tmo_hit(tmo_hit)
  );

  assign delay_done = tmr_q == TMR_W'(ZCD_DELAY - 1);

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q + TMR_W'(1);
    len_d  = len_q;
    stop_d = 1'b0;
    tmo_d  = 1'b0;
    launch = 1'b0;
    if (!enable) begin
      st_d  = ST_IDLE;
      tmr_d = '0;
    end else begin
      case (st_q)
        ST_IDLE: launch = 1'b1;
        ST_ON: if (end_on) begin
          st_d   = ST_OFF;
          tmr_d  = '0;
          stop_d = stop_hit;
        end
        ST_OFF: if (zcd_valid) begin
          st_d  = ST_DELAY;
          tmr_d = '0;
        end else if (tmo_hit) begin
          launch = 1'b1;
          tmo_d  = 1'b1;
        end
        ST_DELAY: if (delay_done) launch = 1'b1;
        ST_SKIP: if (tmo_hit) begin
          launch = 1'b1;
          tmo_d  = 1'b1;
        end
        default: begin
          st_d  = ST_IDLE;
          tmr_d = '0;
        end
      endcase
      if (launch) begin
        tmr_d = '0;
        if (on_count == '0) begin
          st_d = ST_SKIP;
        end else begin
          st_d  = ST_ON;
          len_d = on_count;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      len_q  <= '0;
      stop_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      len_q  <= len_d;
      stop_q <= stop_d;
      tmo_q  <= tmo_d;
    end
  end

  assign drive       = st_q == ST_ON;
  assign stop_evt    = stop_q;
  assign zcd_tmo_evt = tmo_q;

  // R8: idle within one edge of enable dropping
  p_enable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !drive);

  // R4: hard-stop strobe coincides with the falling drive edge
  p_stop_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |-> (!drive && $past(drive)));

  // R4: no termination inside the hard-stop blank unless the count ends
  p_min_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && enable && tmr_q < TMR_W'(LEB_STOP) &&
     (tmr_q + TMR_W'(1)) < TMR_W'(len_q)) |=> drive);

  // R7: timeout strobe follows a low phase and lasts one cycle
  p_tmo_after_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_tmo_evt |-> !$past(drive));
  p_tmo_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_tmo_evt |=> !zcd_tmo_evt);

  // R5: no detection accepted inside the zero-current blank
  p_zcd_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OFF && tmr_q < TMR_W'(ZCD_BLANK) && enable) |=> st_q != ST_DELAY);

  // R9: a zero count never yields a pulse
  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && launch && on_count == '0) |=> !drive);

endmodule

// File: tb/crm_switch_seq_bench.sv
module crm_switch_seq_bench;

  localparam int ON_W        = 12;
  localparam int LEB_LIM     = 32;
  localparam int LEB_STOP    = 12;
  localparam int ZCD_BLANK   = 30;
  localparam int ZCD_DELAY   = 50;
  localparam int ZCD_TIMEOUT = 3200;
  localparam int NEVER       = 1000000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, enable = 1'b0, dim_active = 1'b0;
  logic ilim_nom = 1'b0, ilim_red = 1'b0, ilim_stop = 1'b0, zcd_flag = 1'b0;
  logic [ON_W-1:0] on_count = '0;
  logic drive, stop_evt, zcd_tmo_evt;

  crm_switch_seq #(
    .ON_W(ON_W), .LEB_LIM(LEB_LIM), .LEB_STOP(LEB_STOP),
    .ZCD_BLANK(ZCD_BLANK), .ZCD_DELAY(ZCD_DELAY), .ZCD_TIMEOUT(ZCD_TIMEOUT)
  ) u_crm_switch_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dim_active(dim_active),
    .ilim_nom(ilim_nom), .ilim_red(ilim_red), .ilim_stop(ilim_stop),
    .zcd_flag(zcd_flag), .on_count(on_count), .drive(drive),
    .stop_evt(stop_evt), .zcd_tmo_evt(zcd_tmo_evt)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int a, input int blank, input int g_end);
    int e;
    e = (a > blank) ? a : blank;
    if (a >= NEVER || e >= g_end) return NEVER;
    return e;
  endfunction

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // width of a pulse and whether the hard stop ends it
  function automatic int exp_end(input int on, input bit dim, input int an,
                                 input int ar, input int as, input int ge);
    int el;
    el = dim ? eff(ar, LEB_LIM, ge) : eff(an, LEB_LIM, ge);
    return min3(on - 1, el, eff(as, LEB_STOP, ge));
  endfunction

  task automatic on_phase(input int on, input bit dim, input int an, input int ar,
                          input int as, input int ge, input string req);
    int k = 0;
    int e_end, e_stop;
    dim_active = dim;
    while (drive && k < 70000) begin
      ilim_nom  = (k >= an) && (k < ge);
      ilim_red  = (k >= ar) && (k < ge);
      ilim_stop = (k >= as) && (k < ge);
      zcd_flag  = 1'b0;
      if (k == 1) on_count = ON_W'($urandom);
      k++;
      @(negedge clk);
    end
    e_end  = exp_end(on, dim, an, ar, as, ge);
    e_stop = (eff(as, LEB_STOP, ge) == e_end) ? 1 : 0;
    chk(k == e_end + 1, {req, " width"}, k, e_end + 1);
    chk(int'(stop_evt) == e_stop, {req, " R4 stop_evt"}, int'(stop_evt), e_stop);
  endtask

  task automatic off_phase(input int z, input int ze, input int next_on, input string req);
    int j = 0;
    int ez, e_off, e_tmo;
    on_count = ON_W'(next_on);
    while (!drive && j < ZCD_TIMEOUT + ZCD_DELAY + 100) begin
      ilim_nom  = 1'b0;
      ilim_red  = 1'b0;
      ilim_stop = 1'b0;
      zcd_flag  = (j >= z) && (j < ze);
      if (j == 1) chk(stop_evt == 1'b0, "R4 strobe length", int'(stop_evt), 0);
      j++;
      @(negedge clk);
    end
    ez = eff(z, ZCD_BLANK, ze);
    if (ez <= ZCD_TIMEOUT - 1) begin
      e_off = ez + ZCD_DELAY + 1;
      e_tmo = 0;
    end else begin
      e_off = ZCD_TIMEOUT;
      e_tmo = 1;
    end
    chk(j == e_off, {req, " off width"}, j, e_off);
    chk(int'(zcd_tmo_evt) == e_tmo, {req, " R7 tmo strobe"}, int'(zcd_tmo_evt), e_tmo);
  endtask

  function automatic int pick_trip(input int on);
    if ($urandom % 3 == 0) return int'($urandom % (on + 20));
    return NEVER;
  endfunction

  initial begin
    int unsigned seed_init;
    int cur_on, hi, lo;
    seed_init = $urandom(32'd4711);
    on_count = ON_W'(100);
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(drive == 1'b0 && stop_evt == 1'b0 && zcd_tmo_evt == 1'b0, "R10 reset outputs",
        int'({drive, stop_evt, zcd_tmo_evt}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(drive == 1'b0, "R8 idle while disabled", int'(drive), 0);
    enable = 1'b1;
    @(negedge clk);
    chk(drive == 1'b1, "R8 first pulse immediate", int'(drive), 1);

    on_phase(100, 1'b0, NEVER, NEVER, NEVER, NEVER, "R1 count end");
    off_phase(60, NEVER, 80, "R6 delayed restart");
    on_phase(80, 1'b0, 0, NEVER, NEVER, LEB_LIM, "R2 limit glitch in blank");
    off_phase(0, ZCD_BLANK, 200, "R5 zcd glitch in blank");
    on_phase(200, 1'b0, 50, NEVER, NEVER, NEVER, "R2 limit trip");
    off_phase(5, NEVER, 200, "R5 early zcd held");
    on_phase(200, 1'b1, 10, NEVER, NEVER, NEVER, "R3 nominal ignored while dimming");
    off_phase(20, NEVER, 200, "R6 zcd");
    on_phase(200, 1'b1, NEVER, 70, NEVER, NEVER, "R3 reduced limit");
    off_phase(NEVER, NEVER, 200, "R7 timeout");
    on_phase(200, 1'b0, NEVER, 40, NEVER, NEVER, "R3 reduced ignored undimmed");
    off_phase(ZCD_TIMEOUT - 1, NEVER, 200, "R7 zcd wins last cycle");
    on_phase(200, 1'b0, NEVER, NEVER, 3, NEVER, "R4 hard stop");
    off_phase(100, NEVER, 200, "R6 zcd");
    on_phase(200, 1'b0, NEVER, NEVER, 0, LEB_STOP, "R4 stop glitch in blank");
    off_phase(40, NEVER, 1, "R6 zcd");
    on_phase(1, 1'b0, NEVER, NEVER, NEVER, NEVER, "R1 count of one");
    cur_on = 40 + int'($urandom % 560);
    off_phase(30, NEVER, cur_on, "R6 zcd at blank edge");

    for (int it = 0; it < 40; it++) begin
      int z, nxt;
      on_phase(cur_on, 1'($urandom), pick_trip(cur_on), pick_trip(cur_on),
               pick_trip(cur_on), NEVER, "R1 R2 R3 R4 random");
      z   = ($urandom % 8 == 0) ? NEVER : int'($urandom % 200);
      nxt = 40 + int'($urandom % 560);
      off_phase(z, NEVER, nxt, "R5 R6 R7 random");
      cur_on = nxt;
    end

    on_phase(cur_on, 1'b0, NEVER, NEVER, NEVER, NEVER, "R1 count end");
    off_phase(50, NEVER, 300, "R6 zcd");

    // R8: drop enable mid-pulse
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(drive == 1'b0, "R8 drive low after disable", int'(drive), 0);
    zcd_flag = 1'b1;
    hi = 0;
    repeat (50) begin
      @(negedge clk);
      if (drive) hi++;
    end
    chk(hi == 0, "R8 stays idle", hi, 0);

    // R9: zero count start
    on_count = '0;
    enable   = 1'b1;
    @(negedge clk);
    chk(drive == 1'b0, "R9 zero count no pulse", int'(drive), 0);
    lo = 0;
    while (!drive && lo < ZCD_TIMEOUT + 100) begin
      if (lo == 100) on_count = ON_W'(60);
      lo++;
      @(negedge clk);
    end
    chk(lo == ZCD_TIMEOUT, "R9 waits full timeout", lo, ZCD_TIMEOUT);
    chk(zcd_tmo_evt == 1'b1, "R9 timeout strobe", int'(zcd_tmo_evt), 1);
    on_phase(60, 1'b0, NEVER, NEVER, NEVER, NEVER, "R9 pulse after timeout");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule